// File: doc/BRIEF.md
# Hitless Reference Switching Phase-Step Corrector

This block sits in front of a digital PLL. It receives two reference clocks, primary and secondary, and a feedback clock from the PLL, all sampled in a fast system clock domain. It produces a one-cycle "virtual reference" pulse for every falling edge of the chosen reference. That pulse passes through a programmable delay counted in system clock cycles.

When the corrector is enabled and the select input changes, a control state machine runs a fixed sequence. First it silences the output. Then it moves the active input to the new reference. Next it measures how many cycles lie between a falling edge of the new reference and the next falling edge of the feedback. Finally it loads that count into the delay. As a result, the virtual reference lines up with the feedback and the PLL sees no phase step.

When the corrector is disabled, the selected reference passes through with zero delay and select changes act at once. A two-bit frequency code picks the nominal reference period. The code is captured only during reset.

The states and their transitions are as follows:
- IDLE goes to TRACK once a valid code is held.
- TRACK goes to HOLD when the corrector is enabled and the select differs from the active input.
- HOLD always goes to MEASURE; this is where the active input is switched.
- MEASURE goes to LOAD when a feedback edge completes the measurement.
- MEASURE goes back to TRACK on timeout, and the old delay is kept.
- LOAD goes to TRACK.
- Clearing the enable sends HOLD or MEASURE to TRACK.

Top module: `phase_step_corrector`

## Requirements
- R1: The frequency code is captured while reset is low. Code 01 selects the T1-rate period (P_T1 cycles), code 10 the E1-rate period (P_E1) and code 11 the 8 kHz period (P_8K). Changes to the code after reset has been released have no effect until the next reset.
- R2: Code 00 is reserved. `fs_bad` is then 1, and `vref` stays 0 for as long as that code is latched.
- R3: With the corrector disabled, `vref` is high for exactly one cycle, in the cycle after the selected reference is first seen low following a high level (its falling edge). Rising edges produce nothing. A select change takes effect from the next clock edge.
- R4: While reset is low, `vref` is 0 and `switching` is 1. One clock edge after reset is released with a valid code, `switching` is 0.
- R5: With the corrector enabled, `switching` is 1 in the cycle after a select change, and `vref` stays 0 for as long as `switching` is 1.
- R6: The state machine moves the active reference to the newly selected input during HOLD, before any measurement begins.
- R7: The loaded delay equals the number of cycles from a falling edge of the new reference to the next falling edge of the feedback. After the switch, each `vref` pulse therefore appears in the cycle after a feedback falling edge.
- R8: If no feedback edge completes the measurement within 2 reference periods of entering MEASURE, the machine returns to TRACK and keeps the previous delay. `switching` is high for exactly 2·period+1 cycles in this case.
- R9: A high `tie_rst` clears the delay to zero at the next clock edge.
- R10: The delay is always smaller than one reference period, so there is exactly one `vref` pulse per reference period in steady state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low; latches the frequency code |
| ref_pri | input | 1 | Primary reference clock |
| ref_sec | input | 1 | Secondary reference clock |
| fb_in | input | 1 | Feedback clock from the PLL |
| sel_sec | input | 1 | 1 selects the secondary reference, 0 the primary |
| tie_en | input | 1 | Enables the phase-step corrector |
| tie_rst | input | 1 | Clears the programmable delay to zero |
| fs_code | input | 2 | Nominal frequency code (01 T1, 10 E1, 11 8 kHz, 00 reserved) |
| vref | output | 1 | Virtual reference pulse to the PLL |
| fs_bad | output | 1 | Latched frequency code is reserved |
| switching | output | 1 | State machine is not in TRACK |

## Verification
Some properties are checked by assertions on every cycle:
- the output stays silent while switching or under a reserved code;
- the latched code stays frozen after reset;
- HOLD hands over the active input;
- the measurement window stays bounded;
- the delay stays below one period;
- the delay is cleared after a corrector reset.

Other behaviour can only be shown by the bench scenarios, because it depends on phase relations across many cycles. This covers the exact cycle of each virtual pulse relative to reference and feedback edges, the alignment to feedback after a switch, the delay kept after a timeout, and the pass-through timing when the corrector is disabled.

// File: rtl/psc_pkg.sv
package psc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_MEASURE,
        ST_LOAD,
        ST_TRACK
    } psc_state_t;

    localparam logic [1:0] FS_RESERVED = 2'b00;
    localparam logic [1:0] FS_T1       = 2'b01;
    localparam logic [1:0] FS_E1       = 2'b10;
    localparam logic [1:0] FS_8K       = 2'b11;
endpackage

// File: rtl/psc_fall_detect.sv
module psc_fall_detect #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] fall
);
    // One history flop per line; a fall is "was high, now low".
    for (genvar i = 0; i < N; i++) begin : g_line
        logic prev;
        always_ff @(posedge clk) begin
            if (!rst_n) prev <= 1'b0;
            else        prev <= din[i];
        end
        assign fall[i] = prev & ~din[i];
    end
endmodule

// File: rtl/psc_delay.sv
module psc_delay #(
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pulse_in,
    input  logic [DW-1:0] dly,
    output logic          pulse_out
);
    logic [DW-1:0] cnt;
    logic          pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            pend      <= 1'b0;
            pulse_out <= 1'b0;
        end else begin
            pulse_out <= 1'b0;
            if (pulse_in) begin
                if (dly == '0) begin
                    pulse_out <= 1'b1;
                    pend      <= 1'b0;
                end else begin
                    cnt  <= dly;
                    pend <= 1'b1;
                end
            end else if (pend) begin
                if (cnt == DW'(1)) begin
                    pulse_out <= 1'b1;
                    pend      <= 1'b0;
                end
                cnt <= cnt - DW'(1);
            end
        end
    end

    // R7: a pending pulse always has cycles left to count
    p_pending_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (cnt != '0));
endmodule

// File: rtl/psc_ctrl.sv
module psc_ctrl
    import psc_pkg::*;
#(
    parameter int P_T1 = 20,
    parameter int P_E1 = 16,
    parameter int P_8K = 48,
    parameter int DW   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    fs_code,
    input  logic          tie_en,
    input  logic          tie_rst,
    input  logic          sel_sec,
    input  logic          fall_pri,
    input  logic          fall_sec,
    input  logic          fall_fb,
    output logic          act_sec,
    output logic [DW-1:0] dly_eff,
    output logic          out_en,
    output logic          fs_bad,
    output logic          switching
);
    psc_state_t    state, nxt;
    logic [1:0]    fs_q;
    logic [DW-1:0] per, per_lim, dly, meas, mcnt, tcnt;
    logic          armed, new_fall, done, timeout;

    // frequency code is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= fs_code;
    end

    assign fs_bad = (fs_q == FS_RESERVED);

    always_comb begin
        unique case (fs_q)
            FS_T1:   per = DW'(P_T1);
            FS_E1:   per = DW'(P_E1);
            FS_8K:   per = DW'(P_8K);
            default: per = DW'(P_8K);
        endcase
    end

    assign per_lim  = {per[DW-2:0], 1'b0} - DW'(1);
    assign new_fall = act_sec ? fall_sec : fall_pri;
    assign done     = fall_fb && (armed || new_fall);
    assign timeout  = (tcnt == per_lim);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (!fs_bad) nxt = ST_TRACK;
            ST_TRACK:   if (tie_en && (sel_sec != act_sec)) nxt = ST_HOLD;
            ST_HOLD:    nxt = tie_en ? ST_MEASURE : ST_TRACK;
            ST_MEASURE: begin
                if (!tie_en)      nxt = ST_TRACK;
                else if (done)    nxt = ST_LOAD;
                else if (timeout) nxt = ST_TRACK;
            end
            ST_LOAD:    nxt = ST_TRACK;
            default:    nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sec <= sel_sec;
            dly     <= '0;
            meas    <= '0;
            mcnt    <= '0;
            tcnt    <= '0;
            armed   <= 1'b0;
        end else begin
            unique case (state)
                ST_HOLD: begin
                    act_sec <= sel_sec;
                    armed   <= 1'b0;
                    tcnt    <= '0;
                    mcnt    <= '0;
                end
                ST_MEASURE: begin
                    tcnt <= tcnt + DW'(1);
                    if (armed) begin
                        mcnt <= mcnt + DW'(1);
                    end else if (new_fall) begin
                        armed <= 1'b1;
                        mcnt  <= DW'(1);
                    end
                    if (done) meas <= armed ? mcnt : '0;
                end
                ST_LOAD: dly <= (meas >= per) ? (meas - per) : meas;
                default: if (!tie_en) act_sec <= sel_sec;
            endcase
            if (tie_rst) dly <= '0;
        end
    end

    assign dly_eff   = tie_en ? dly : '0;
    assign out_en    = (state == ST_TRACK) && !fs_bad;
    assign switching = (state != ST_TRACK);

    p_code_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(fs_q));
    p_hold_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (act_sec == $past(sel_sec)));
    p_window_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEASURE) |-> (tcnt <= per_lim));
    p_clear_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tie_rst |=> (dly == '0));
    p_delay_in_period_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (dly < per));
endmodule

// File: rtl/phase_step_corrector.sv
module phase_step_corrector #(
    parameter int P_T1 = 20,
    parameter int P_E1 = 16,
    parameter int P_8K = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_pri,
    input  logic       ref_sec,
    input  logic       fb_in,
    input  logic       sel_sec,
    input  logic       tie_en,
    input  logic       tie_rst,
    input  logic [1:0] fs_code,
    output logic       vref,
    output logic       fs_bad,
    output logic       switching
);
    localparam int PMAX_A = (P_T1 > P_E1) ? P_T1 : P_E1;
    localparam int PMAX   = (PMAX_A > P_8K) ? PMAX_A : P_8K;
    localparam int DW     = $clog2(2 * PMAX + 1);

    logic [2:0]    falls;
    logic          act_sec, out_en, dly_pulse, sel_fall;
    logic [DW-1:0] dly_eff;

    psc_fall_detect #(.N(3)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({fb_in, ref_sec, ref_pri}),
        .fall (falls)
    );

    psc_ctrl #(.P_T1(P_T1), .P_E1(P_E1), .P_8K(P_8K), .DW(DW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs_code  (fs_code),
        .tie_en   (tie_en),
        .tie_rst  (tie_rst),
        .sel_sec  (sel_sec),
        .fall_pri (falls[0]),
        .fall_sec (falls[1]),
        .fall_fb  (falls[2]),
        .act_sec  (act_sec),
        .dly_eff  (dly_eff),
        .out_en   (out_en),
        .fs_bad   (fs_bad),
        .switching(switching)
    );

    assign sel_fall = act_sec ? falls[1] : falls[0];

    psc_delay #(.DW(DW)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (sel_fall),
        .dly      (dly_eff),
        .pulse_out(dly_pulse)
    );

    assign vref = dly_pulse & out_en;

    p_bad_code_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fs_bad |-> !vref);
    p_quiet_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        switching |-> !vref);
endmodule

// File: tb/phase_step_corrector_test.sv
`timescale 1ns/1ps
module phase_step_corrector_test;
    localparam int P_T1 = 20;
    localparam int P_E1 = 16;
    localparam int P_8K = 48;
    localparam int NV   = 6;
    // {code, primary phase, secondary phase, feedback phase, corrector enable}
    localparam int VEC [NV][5] = '{
        '{1, 0, 7, 12, 1},
        '{2, 3, 10, 5, 1},
        '{3, 5, 30, 40, 1},
        '{1, 2, 11, 11, 1},
        '{2, 4, 9, 0, 0},
        '{3, 10, 20, 0, 0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ref_pri = 1'b1, ref_sec = 1'b1, fb_in = 1'b1;
    logic sel_sec = 1'b0, tie_en = 1'b0, tie_rst = 1'b0;
    logic [1:0] fs_code = 2'b01;
    logic vref, fs_bad, switching;

    always #2.5 clk = ~clk;

    phase_step_corrector #(.P_T1(P_T1), .P_E1(P_E1), .P_8K(P_8K)) uut (
        .clk(clk), .rst_n(rst_n), .ref_pri(ref_pri), .ref_sec(ref_sec),
        .fb_in(fb_in), .sel_sec(sel_sec), .tie_en(tie_en), .tie_rst(tie_rst),
        .fs_code(fs_code), .vref(vref), .fs_bad(fs_bad), .switching(switching)
    );

    int checks = 0, errors = 0, cyc = 0;
    int ph_pri = 0, ph_sec = 0, ph_fb = 0, per_b = P_T1;
    bit fb_on = 1'b1, finished = 1'b0;
    logic s_vref, s_sw, s_bad;
    int s_cyc, hits, mism, sw_len;

    function automatic int per_of(input int code);
        case (code)
            1: return P_T1;
            2: return P_E1;
            default: return P_8K;
        endcase
    endfunction

    // falling edge of a reference at every index where (c - ph) mod per == 0
    function automatic logic lvl(input int c, input int ph);
        return ((c + 100 * per_b - ph) % per_b) >= (per_b / 2);
    endfunction

    task automatic step();
        @(negedge clk);
        s_vref = vref;
        s_sw   = switching;
        s_bad  = fs_bad;
        s_cyc  = cyc;
        cyc++;
        ref_pri = lvl(cyc, ph_pri);
        ref_sec = lvl(cyc, ph_sec);
        fb_in   = fb_on ? lvl(cyc, ph_fb) : 1'b1;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run_phase(input int ph, input int n, input string tag);
        hits = 0;
        mism = 0;
        repeat (n) begin
            step();
            if (s_vref) hits++;
            if (s_vref !== (((s_cyc + 100 * per_b - ph) % per_b) == 0)) mism++;
        end
        check(mism == 0, tag, "misaligned vref cycles", mism, 0);
    endtask

    task automatic do_reset(input int code);
        rst_n   = 1'b0;
        fs_code = 2'(code);
        per_b   = per_of(code);
        repeat (3) step();
        check(s_vref == 1'b0 && s_sw == 1'b1, "R4", "vref/switching in reset",
              {s_vref, s_sw}, 1);
        rst_n = 1'b1;
        step();
        step();
    endtask

    task automatic sw_enabled();
        int quiet;
        sel_sec = ~sel_sec;
        step();
        check(s_sw == 1'b1, "R5", "switching after select change", s_sw, 1);
        quiet  = s_vref ? 1 : 0;
        sw_len = 1;
        while (s_sw && sw_len < 4 * per_b) begin
            step();
            sw_len++;
            if (s_vref && s_sw) quiet++;
        end
        check(quiet == 0, "R5", "vref pulses while switching", quiet, 0);
    endtask

    initial begin
        for (int v = 0; v < NV; v++) begin
            tie_en  = VEC[v][4][0];
            ph_pri  = VEC[v][1];
            ph_sec  = VEC[v][2];
            ph_fb   = VEC[v][3];
            sel_sec = 1'b0;
            fb_on   = 1'b1;
            do_reset(VEC[v][0]);
            check(s_sw == 1'b0, "R4", "switching after reset release", s_sw, 0);
            repeat (per_b) step();
            run_phase(ph_pri, 2 * per_b, "R3");
            if (tie_en) begin
                sw_enabled();
                repeat (per_b + 2) step();
                run_phase(ph_fb, 2 * per_b, "R7");
                check(hits == 2, "R10", "pulses in two periods", hits, 2);
            end else begin
                sel_sec = 1'b1;
                step();
                step();
                run_phase(ph_sec, 2 * per_b, "R3");
            end
        end

        // reserved code
        tie_en = 1'b0; sel_sec = 1'b0; ph_pri = 1;
        do_reset(0);
        check(s_bad == 1'b1, "R2", "fs_bad for reserved code", s_bad, 1);
        hits = 0;
        repeat (2 * per_b) begin
            step();
            if (s_vref) hits++;
        end
        check(hits == 0, "R2", "vref pulses under reserved code", hits, 0);

        // code ignored after reset, re-latched on reset
        ph_pri = 3;
        do_reset(1);
        fs_code = 2'b11;
        repeat (per_b) step();
        run_phase(3, 2 * per_b, "R1");
        fs_code = 2'b00;
        step();
        check(s_bad == 1'b0, "R1", "fs_bad after code change without reset", s_bad, 0);
        do_reset(2);
        repeat (per_b) step();
        run_phase(3, 2 * per_b, "R1");

        // normal switch, then timeout on the way back, then delay clear
        tie_en = 1'b1; sel_sec = 1'b0; fb_on = 1'b1;
        ph_pri = 0; ph_sec = 8; ph_fb = 13;
        do_reset(1);
        repeat (per_b) step();
        sw_enabled();
        repeat (per_b + 2) step();
        run_phase(13, 2 * per_b, "R7");
        fb_on = 1'b0;
        sw_enabled();
        check(sw_len == 2 * per_b + 2, "R8", "samples until TRACK after timeout",
              sw_len, 2 * per_b + 2);
        repeat (per_b + 2) step();
        run_phase(5, 2 * per_b, "R6");
        tie_rst = 1'b1;
        step();
        tie_rst = 1'b0;
        repeat (per_b) step();
        run_phase(0, 2 * per_b, "R9");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule